// File: doc/BRIEF.md
# System Tick Timer with Compare Flag

This block is a memory-mapped up-counter that gives software a time base. A bus master programs a compare value and a start count, then sets the run bit. The counter then advances on every clock or on every eighth clock. When the count steps onto the compare value, the block latches a sticky match flag. That flag can drive an interrupt line, which a software trigger bit can also assert directly.

A control bit picks what happens after a match. With auto-return on, the counter falls back to zero on the next tick, so the match repeats every compare+1 ticks. With it off, the counter runs on to all ones and wraps to zero. Software can overwrite the count at any time, and a write takes precedence over a tick in the same cycle. Reads are combinational from the offset presented with the select strobe.

Top module: `systick_timer`

## Requirements
- R1: After reset, the control, status, count and compare registers all read zero, and `tick_irq` is low.
- R2: Registers sit at byte offsets 0x00 (control), 0x04 (status), 0x08 (count) and 0x10 (compare). Control bits are: bit 0 run, bit 1 interrupt enable, bit 2 full-rate clock select, bit 3 auto-return, bit 31 software trigger. Other control bits read 0. Any other offset reads 0, and writes to it change nothing.
- R3: With run=1 and full-rate=1, the count rises by one on every clock edge, starting at the first edge after the write that sets run.
- R4: With run=1 and full-rate=0, the count rises once every 8 clocks. The first step comes on the 8th edge after the write that sets run. Clearing run resets the divide phase, so the next enable again waits a full 8 clocks.
- R5: With run=0, the count holds its value.
- R6: With auto-return=1, a tick taken while the count equals the compare value loads zero, giving a period of compare+1 ticks.
- R7: With auto-return=0, the count passes the compare value and wraps from 0xFFFFFFFF to 0.
- R8: Status bit 0 sets on the tick that makes the count equal to the compare value, and it stays set. Loading the count through a write never sets it.
- R9: A status write with bit 0 = 0 clears the flag, and a status write with bit 0 = 1 leaves it unchanged. If a match and a clear land in the same cycle, the flag stays set.
- R10: A count write loads the written value. If a tick occurs in the same cycle, the write wins over the tick.
- R11: `tick_irq` = (match flag AND interrupt enable) OR software trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tick_irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a status clear that lands on the very edge where the counter steps onto the compare value. The bench reaches it with a small compare value and the full-rate clock, and counts edges from the enabling write so the clearing write commits exactly on the match edge. A second hard case is a divide phase that stopped partway. The bench enables the divided clock, stops it after three clocks and enables it again, then checks that the first step still takes eight edges.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int unsigned ST_DATA_W = 32;
  localparam int unsigned ST_ADDR_W = 5;

  typedef logic [ST_DATA_W-1:0] st_word_t;
  typedef logic [ST_ADDR_W-1:0] st_addr_t;

  localparam st_addr_t ST_OFF_CTRL = 5'h00;
  localparam st_addr_t ST_OFF_STAT = 5'h04;
  localparam st_addr_t ST_OFF_CNT  = 5'h08;
  localparam st_addr_t ST_OFF_CMP  = 5'h10;

  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_IEN    = 1;
  localparam int unsigned CB_FULL   = 2;
  localparam int unsigned CB_RELOAD = 3;
  localparam int unsigned CB_SWI    = ST_DATA_W - 1;

  localparam int unsigned ST_DIV = 8;

  typedef struct packed {
    logic swi;
    logic reload;
    logic full;
    logic ien;
    logic run;
  } st_ctrl_t;

  // count after one tick, given the auto-return mode
  function automatic st_word_t st_next_count(st_word_t cnt, st_word_t cmp, logic reload);
    if (reload && (cnt == cmp)) return '0;
    return cnt + 1'b1;
  endfunction

  function automatic st_word_t st_ctrl_to_word(st_ctrl_t c);
    st_word_t w;
    w            = '0;
    w[CB_RUN]    = c.run;
    w[CB_IEN]    = c.ien;
    w[CB_FULL]   = c.full;
    w[CB_RELOAD] = c.reload;
    w[CB_SWI]    = c.swi;
    return w;
  endfunction

  function automatic st_ctrl_t st_word_to_ctrl(st_word_t w);
    st_ctrl_t c;
    c.run    = w[CB_RUN];
    c.ien    = w[CB_IEN];
    c.full   = w[CB_FULL];
    c.reload = w[CB_RELOAD];
    c.swi    = w[CB_SWI];
    return c;
  endfunction
endpackage

// File: rtl/systick_prescaler.sv
module systick_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)              phase <= '0;
    else if (!run)           phase <= '0;
    else if (phase == LAST)  phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  assign hit = run && (phase == LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R4
      presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
      // R4
      presc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !hit);
    end
  endgenerate
endmodule

// File: rtl/systick_counter.sv
module systick_counter
  import systick_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     reload,
  input  st_word_t cmp,
  input  logic     wr_en,
  input  st_word_t wr_data,
  output st_word_t cnt,
  output logic     match_evt
);
  st_word_t nxt_tick;

  assign nxt_tick  = st_next_count(cnt, cmp, reload);
  assign match_evt = tick && !wr_en && (nxt_tick == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wr_data;
    else if (tick)  cnt <= nxt_tick;
  end

  // R10
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wr_data));
  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt));
  // R6
  cnt_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && reload && cnt == cmp) |=> cnt == '0);
  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && !reload) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bus_sel,
  input  logic     bus_wr,
  input  st_addr_t bus_addr,
  input  st_word_t bus_wdata,
  input  st_word_t cnt,
  input  logic     match_evt,
  output st_ctrl_t ctrl,
  output st_word_t cmp,
  output logic     cnt_wr,
  output logic     flag,
  output st_word_t bus_rdata
);
  logic wr_any, wr_ctrl, wr_stat, wr_cmp, flag_clr;

  assign wr_any   = bus_sel && bus_wr;
  assign wr_ctrl  = wr_any && (bus_addr == ST_OFF_CTRL);
  assign wr_stat  = wr_any && (bus_addr == ST_OFF_STAT);
  assign cnt_wr   = wr_any && (bus_addr == ST_OFF_CNT);
  assign wr_cmp   = wr_any && (bus_addr == ST_OFF_CMP);
  assign flag_clr = wr_stat && !bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      cmp  <= '0;
    end else begin
      if (wr_ctrl) ctrl <= st_word_to_ctrl(bus_wdata);
      if (wr_cmp)  cmp  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flag <= 1'b0;
    else if (match_evt) flag <= 1'b1;
    else if (flag_clr)  flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        ST_OFF_CTRL: bus_rdata = st_ctrl_to_word(ctrl);
        ST_OFF_STAT: bus_rdata = {{(ST_DATA_W-1){1'b0}}, flag};
        ST_OFF_CNT:  bus_rdata = cnt;
        ST_OFF_CMP:  bus_rdata = cmp;
        default:     bus_rdata = '0;
      endcase
    end
  end

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match_evt) |=> !flag);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tick_irq
);
  st_ctrl_t ctrl;
  st_word_t cmp, cnt;
  logic     cnt_wr, flag, match_evt, presc_hit, tick;

  systick_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt),
    .match_evt (match_evt),
    .ctrl      (ctrl),
    .cmp       (cmp),
    .cnt_wr    (cnt_wr),
    .flag      (flag),
    .bus_rdata (bus_rdata)
  );

  systick_prescaler #(.DIV(ST_DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl.run),
    .hit   (presc_hit)
  );

  assign tick = ctrl.run && (ctrl.full || presc_hit);

  systick_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reload    (ctrl.reload),
    .cmp       (cmp),
    .wr_en     (cnt_wr),
    .wr_data   (bus_wdata),
    .cnt       (cnt),
    .match_evt (match_evt)
  );

  assign tick_irq = (flag && ctrl.ien) || ctrl.swi;

  // R11
  irq_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.swi |-> tick_irq);
  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.swi && !flag) |-> !tick_irq);
  // R3
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && ctrl.full) |-> tick);
endmodule

// File: tb/tb_systick_timer.sv
module tb_systick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int nvec = 0;
  int nbad = 0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_CNT = 5'h08, A_CMP = 5'h10, A_GAP = 5'h0C;

  always #4 clk = ~clk;

  systick_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stop, load count and compare, clear flag (no tick while stopped)
  task automatic setup(input logic [31:0] cmpv, input logic [31:0] cntv);
    wr(A_CTRL, 32'h0);
    wr(A_CNT, cntv);
    wr(A_CMP, cmpv);
    wr(A_STAT, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset values
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); chk("R1 stat", d, 32'h0);
    rd(A_CNT, d);  chk("R1 cnt", d, 32'h0);
    rd(A_CMP, d);  chk("R1 cmp", d, 32'h0);
    chk("R1 irq", {31'b0, tick_irq}, 32'h0);

    // R2 control bit layout, reserved bits read 0
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R2 ctrl mask", d, 32'h8000_000F);
    wr(A_CTRL, 32'h0);

    // R3 full rate counting sweep
    setup(32'hFFFF_0000, 32'h0);
    wr(A_CTRL, 32'h5);
    for (int m = 1; m <= 20; m++) begin
      wait_n(1);
      rd(A_CNT, d); chk("R3 full count", d, m);
    end

    // R5 stop: committing edge still ticks, then holds
    wr(A_CTRL, 32'h0);
    rd(A_CNT, d); chk("R5 stop edge", d, 32'd21);
    wait_n(5);
    rd(A_CNT, d); chk("R5 hold", d, 32'd21);

    // R2 unmapped offset: reads 0, write ignored
    wr(A_GAP, 32'hDEAD_BEEF);
    rd(A_GAP, d); chk("R2 gap read", d, 32'h0);
    rd(A_CMP, d); chk("R2 gap no effect", d, 32'hFFFF_0000);
    rd(A_CNT, d); chk("R2 gap cnt", d, 32'd21);

    // R4 divide by 8 sweep
    setup(32'hFFFF_0000, 32'h0);
    wr(A_CTRL, 32'h1);
    for (int m = 1; m <= 40; m++) begin
      wait_n(1);
      rd(A_CNT, d); chk("R4 div count", d, m / 8);
    end

    // R4 prescaler phase cleared by a stop
    setup(32'hFFFF_0000, 32'h0);
    wr(A_CTRL, 32'h1);
    wait_n(3);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h1);
    for (int k = 1; k <= 8; k++) begin
      wait_n(1);
      rd(A_CNT, d); chk("R4 phase reset", d, (k == 8) ? 32'd1 : 32'd0);
    end

    // R6 and R8 auto-return sweep over small compare values
    for (int c = 0; c <= 4; c++) begin
      setup(c, 32'h0);
      wr(A_CTRL, 32'hD);
      for (int k = 1; k <= 3 * (c + 1); k++) begin
        wait_n(1);
        rd(A_CNT, d);  chk("R6 return count", d, k % (c + 1));
        rd(A_STAT, d); chk("R8 flag on match", d, (k >= c) ? 32'd1 : 32'd0);
      end
    end

    // R7 and R8 free run past compare and wrap at max
    setup(32'd5, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h5);
    for (int k = 1; k <= 9; k++) begin
      wait_n(1);
      rd(A_CNT, d);  chk("R7 wrap count", d, 32'hFFFF_FFFE + k);
      rd(A_STAT, d); chk("R8 flag free run", d, (k >= 7) ? 32'd1 : 32'd0);
    end

    // R9 set wins over clear on the same edge
    setup(32'd3, 32'h0);
    wr(A_CTRL, 32'hD);
    wait_n(2);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R9 set beats clear", d, 32'd1);
    rd(A_CNT, d);  chk("R9 count at match", d, 32'd3);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R9 clear", d, 32'd0);

    // R10 count write while running; R8 write to compare value sets no flag
    setup(32'd1000, 32'h0);
    wr(A_CTRL, 32'h5);
    wait_n(3);
    wr(A_CNT, 32'd100);
    rd(A_CNT, d); chk("R10 write beats tick", d, 32'd100);
    wait_n(1);
    rd(A_CNT, d); chk("R10 resume", d, 32'd101);
    wr(A_CNT, 32'd1000);
    rd(A_STAT, d); chk("R8 write no flag", d, 32'd0);
    wait_n(1);
    rd(A_STAT, d); chk("R8 past compare", d, 32'd0);
    rd(A_CNT, d);  chk("R10 after load", d, 32'd1001);

    // R11 interrupt combinations, R9 write of one keeps flag
    setup(32'd2, 32'h0);
    wr(A_CTRL, 32'h7);
    wait_n(2);
    chk("R11 flag and enable", {31'b0, tick_irq}, 32'd1);
    wr(A_CTRL, 32'h5);
    chk("R11 enable off", {31'b0, tick_irq}, 32'd0);
    wr(A_CTRL, 32'h8000_0000);
    chk("R11 soft trigger", {31'b0, tick_irq}, 32'd1);
    wr(A_CTRL, 32'h0);
    chk("R11 all off", {31'b0, tick_irq}, 32'd0);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R9 write one keeps", d, 32'd1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R9 write zero clears", d, 32'd0);
    wr(A_CTRL, 32'h8000_0002);
    chk("R11 soft without flag", {31'b0, tick_irq}, 32'd1);
    wr(A_CTRL, 32'h2);
    chk("R11 enable without flag", {31'b0, tick_irq}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule